// File: doc/BRIEF.md
# 10BASE-T Link Integrity and Receive Polarity Monitor

This block keeps a 10BASE-T port's link alive and trustworthy. While the transmitter is idle, it sends a short normal link pulse on a fixed interval. It also watches the link pulses arriving from the far end. When none arrive for a long enough span, it drops three separate enables: one for the 10BASE-T transmit path, one for the receive path and one for collision detection. The first valid pulse after such a loss restores all three.

The same block detects a wire pair that has been swapped. It keeps two independent run counters. One counts consecutive received link pulses that arrive inverted. The other counts consecutive received frames whose end-of-packet pulse arrives inverted. If either run reaches its threshold, the block asserts a swap output that the receive datapath uses to flip data polarity, and it raises a status bit. A disable input turns the automatic correction off.

The inputs are already decoded into single-cycle event strobes, each with a polarity flag. Analog slicing and Manchester coding are handled elsewhere.

Top module: `nlp_link_monitor`

## Requirements
- R1: When tx_active is low, lp_tx goes high for exactly PULSE_CYC cycles, and the starts of consecutive pulses are INTERVAL_CYC cycles apart.
- R2: In the cycle after tx_active is sampled high, lp_tx is low, and a pulse in progress is cut short. The interval restarts, so the next pulse starts on the INTERVAL_CYC-th rising edge after tx_active falls.
- R3: The cycle after a rx_lp_evt strobe of either polarity, link_up is high, and tx_en, rx_en and col_en are all high with it.
- R4: A link that is up goes down LOSS_CYC cycles after the last rx_lp_evt. At that point link_up, tx_en, rx_en and col_en all go low. A strobe that arrives in the expiry cycle itself keeps the link up and restarts the timeout.
- R5: While rst_n is low, and in the cycle after it is released, the outputs are as follows: link_up and the three enables are low, lp_tx is low, and pol_swap and pol_status are low.
- R6: The cycle after the LP_INV_RUN-th consecutive inverted link pulse (rx_lp_evt with rx_lp_inv=1), pol_swap and pol_status are high. Both then stay high until reset or auto_pol_dis.
- R7: The cycle after the EOP_INV_RUN-th consecutive inverted packet ending (rx_eop_evt with rx_eop_inv=1), pol_swap and pol_status are high.
- R8: A link pulse with correct polarity (rx_lp_inv=0) clears only the link-pulse run. A packet ending with correct polarity (rx_eop_inv=0) clears only the end-of-packet run. Neither event affects the other run.
- R9: While auto_pol_dis is high, pol_swap is low in that same cycle. On the next edge, pol_status and both runs are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_active | input | 1 | Transmit data present; suppresses link pulses |
| rx_lp_evt | input | 1 | One-cycle strobe: a link pulse was received |
| rx_lp_inv | input | 1 | Polarity of that pulse, 1 = inverted |
| rx_eop_evt | input | 1 | One-cycle strobe: a frame's end-of-packet pulse was received |
| rx_eop_inv | input | 1 | Polarity of that end-of-packet pulse, 1 = inverted |
| auto_pol_dis | input | 1 | 1 turns automatic polarity correction off |
| lp_tx | output | 1 | Transmitted normal link pulse |
| link_up | output | 1 | Link integrity state |
| tx_en | output | 1 | 10BASE-T transmitter enable |
| rx_en | output | 1 | 10BASE-T receiver enable |
| col_en | output | 1 | Collision detection enable |
| pol_swap | output | 1 | Receive polarity inversion control |
| pol_status | output | 1 | Status: inverted polarity was detected and corrected |

## Verification
Two events can land on the same edge: the link-loss timeout running out, and a fresh valid pulse arriving. The bench lets the timer run for exactly LOSS_CYC-1 edges after a pulse, then places a strobe on the expiry edge. It then requires the link to stay up for a full new timeout and to drop exactly one cycle after that. The polarity runs are walked with a vector table that interleaves link-pulse and end-of-packet events. This shows that a correct event on one source leaves the other source's run intact.

// File: rtl/nlp_pkg.sv
package nlp_pkg;

    // Phase of the link pulse generator
    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_PULSE = 1'b1
    } lp_phase_e;

    // A decoded receive event: strobe plus polarity flag (1 = inverted)
    typedef struct packed {
        logic evt;
        logic inv;
    } pol_evt_t;

endpackage

// File: rtl/nlp_pulse_gen.sv
module nlp_pulse_gen
    import nlp_pkg::*;
#(
    parameter int unsigned PULSE_CYC    = 5,
    parameter int unsigned INTERVAL_CYC = 800_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_active_i,
    output logic lp_o
);

    localparam int unsigned IW = $clog2(INTERVAL_CYC);
    localparam int unsigned PW = $clog2(PULSE_CYC + 1);
    localparam logic [IW-1:0] IVL_LAST = IW'(INTERVAL_CYC - 1);
    localparam logic [PW-1:0] WID_LAST = PW'(PULSE_CYC - 1);

    typedef struct packed {
        lp_phase_e     ph;
        logic [IW-1:0] ivl;
        logic [PW-1:0] wid;
    } gen_st_t;

    gen_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tx_active_i) begin
            // transmit data present: quiet line, restart the interval
            st_d.ph  = PH_IDLE;
            st_d.ivl = '0;
            st_d.wid = '0;
        end else if (st_q.ivl == IVL_LAST) begin
            st_d.ivl = '0;
            st_d.ph  = PH_PULSE;
            st_d.wid = '0;
        end else begin
            st_d.ivl = st_q.ivl + 1'b1;
            if (st_q.ph == PH_PULSE) begin
                if (st_q.wid == WID_LAST) begin
                    st_d.ph  = PH_IDLE;
                    st_d.wid = '0;
                end else begin
                    st_d.wid = st_q.wid + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, ivl: '0, wid: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign lp_o = (st_q.ph == PH_PULSE);

    // checker: length of the current high run of lp_o
    logic [PW-1:0] hi_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)    hi_run_q <= '0;
        else if (lp_o) hi_run_q <= hi_run_q + 1'b1;
        else           hi_run_q <= '0;
    end

    a_r1_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        lp_o |-> (hi_run_q < PW'(PULSE_CYC)));

    a_r2_tx_quiets_line: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active_i |=> !lp_o);

endmodule

// File: rtl/nlp_link_timer.sv
module nlp_link_timer #(
    parameter int unsigned LOSS_CYC = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_pulse_i,
    output logic link_up_o
);

    localparam int unsigned LW = $clog2(LOSS_CYC);
    localparam logic [LW-1:0] AGE_LAST = LW'(LOSS_CYC - 1);

    typedef struct packed {
        logic          up;
        logic [LW-1:0] age;
    } lnk_st_t;

    lnk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rx_pulse_i) begin
            // a valid pulse wins over an expiry in the same cycle
            st_d.up  = 1'b1;
            st_d.age = '0;
        end else if (st_q.up) begin
            if (st_q.age == AGE_LAST) begin
                st_d.up  = 1'b0;
                st_d.age = '0;
            end else begin
                st_d.age = st_q.age + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{up: 1'b0, age: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign link_up_o = st_q.up;

    a_r3_pulse_brings_up: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pulse_i |=> link_up_o);

    a_r4_drop_needs_silence: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_up_o) |-> !$past(rx_pulse_i));

endmodule

// File: rtl/nlp_inv_counter.sv
module nlp_inv_counter
    import nlp_pkg::*;
#(
    parameter int unsigned THRESH = 7
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr_i,
    input  pol_evt_t ev_i,
    output logic     hit_o
);

    localparam int unsigned CW = $clog2(THRESH + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(THRESH - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } run_st_t;

    run_st_t st_d, st_q;
    logic    hit;

    always_comb begin
        st_d = st_q;
        hit  = 1'b0;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (ev_i.evt) begin
            if (ev_i.inv) begin
                if (st_q.cnt == CNT_LAST) hit = 1'b1;   // saturate at the last step
                else                      st_d.cnt = st_q.cnt + 1'b1;
            end else begin
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{cnt: '0};
        else        st_q <= st_d;
    end

    assign hit_o = hit;

    a_r8_correct_event_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i.evt && !ev_i.inv && !clr_i) |=> (st_q.cnt == '0));

    a_r6_hit_needs_inverted: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (ev_i.evt && ev_i.inv));

    a_r8_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_LAST);

endmodule

// File: rtl/nlp_pol_track.sv
module nlp_pol_track
    import nlp_pkg::*;
#(
    parameter int unsigned LP_INV_RUN  = 7,
    parameter int unsigned EOP_INV_RUN = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     dis_i,
    input  pol_evt_t lp_i,
    input  pol_evt_t eop_i,
    output logic     swap_o,
    output logic     status_o
);

    typedef struct packed {
        logic det;
    } pol_st_t;

    pol_evt_t [1:0] src;
    logic     [1:0] hit;
    pol_st_t        st_d, st_q;

    assign src = {eop_i, lp_i};

    for (genvar g = 0; g < 2; g++) begin : g_src
        localparam int unsigned THR = (g == 0) ? LP_INV_RUN : EOP_INV_RUN;
        nlp_inv_counter #(.THRESH(THR)) u_run (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (dis_i),
            .ev_i  (src[g]),
            .hit_o (hit[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (dis_i)     st_d.det = 1'b0;
        else if (|hit) st_d.det = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{det: 1'b0};
        else        st_q <= st_d;
    end

    assign swap_o   = st_q.det & ~dis_i;
    assign status_o = st_q.det;

    a_r9_disable_blocks_swap: assert property (@(posedge clk) disable iff (!rst_n)
        dis_i |-> !swap_o);

    a_r9_disable_clears_status: assert property (@(posedge clk) disable iff (!rst_n)
        dis_i |=> !status_o);

    a_r6_detect_is_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o && !dis_i) |=> status_o);

endmodule

// File: rtl/nlp_link_monitor.sv
module nlp_link_monitor
    import nlp_pkg::*;
#(
    parameter int unsigned PULSE_CYC    = 5,
    parameter int unsigned INTERVAL_CYC = 800_000,
    parameter int unsigned LOSS_CYC     = 5_000_000,
    parameter int unsigned LP_INV_RUN   = 7,
    parameter int unsigned EOP_INV_RUN  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_active,
    input  logic rx_lp_evt,
    input  logic rx_lp_inv,
    input  logic rx_eop_evt,
    input  logic rx_eop_inv,
    input  logic auto_pol_dis,
    output logic lp_tx,
    output logic link_up,
    output logic tx_en,
    output logic rx_en,
    output logic col_en,
    output logic pol_swap,
    output logic pol_status
);

    pol_evt_t lp_ev, eop_ev;
    logic     up;

    assign lp_ev  = {rx_lp_evt, rx_lp_inv};
    assign eop_ev = {rx_eop_evt, rx_eop_inv};

    nlp_pulse_gen #(
        .PULSE_CYC    (PULSE_CYC),
        .INTERVAL_CYC (INTERVAL_CYC)
    ) u_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_active_i (tx_active),
        .lp_o        (lp_tx)
    );

    nlp_link_timer #(
        .LOSS_CYC (LOSS_CYC)
    ) u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_pulse_i (rx_lp_evt),
        .link_up_o  (up)
    );

    nlp_pol_track #(
        .LP_INV_RUN  (LP_INV_RUN),
        .EOP_INV_RUN (EOP_INV_RUN)
    ) u_pol (
        .clk      (clk),
        .rst_n    (rst_n),
        .dis_i    (auto_pol_dis),
        .lp_i     (lp_ev),
        .eop_i    (eop_ev),
        .swap_o   (pol_swap),
        .status_o (pol_status)
    );

    assign link_up = up;
    assign tx_en   = up;
    assign rx_en   = up;
    assign col_en  = up;

endmodule

// File: tb/sim_nlp_link_monitor.sv
module sim_nlp_link_monitor;

    localparam int unsigned PULSE    = 5;
    localparam int unsigned INTERVAL = 60;
    localparam int unsigned LOSS     = 200;
    localparam int unsigned NVEC     = 17;

    // row: [2]=source (1 = end-of-packet), [1]=inverted, [0]=expected pol_swap after it
    localparam logic [2:0] VEC [NVEC] = '{
        3'b010, 3'b010, 3'b010, 3'b010, 3'b010, 3'b010,
        3'b000,
        3'b010, 3'b010, 3'b010,
        3'b110, 3'b110,
        3'b100,
        3'b010, 3'b010, 3'b010,
        3'b011
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_active = 1'b0;
    logic rx_lp_evt = 1'b0, rx_lp_inv = 1'b0;
    logic rx_eop_evt = 1'b0, rx_eop_inv = 1'b0;
    logic auto_pol_dis = 1'b0;
    logic lp_tx, link_up, tx_en, rx_en, col_en, pol_swap, pol_status;

    int n_run = 0;
    int n_bad = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    nlp_link_monitor #(
        .PULSE_CYC    (PULSE),
        .INTERVAL_CYC (INTERVAL),
        .LOSS_CYC     (LOSS),
        .LP_INV_RUN   (7),
        .EOP_INV_RUN  (3)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .tx_active (tx_active),
        .rx_lp_evt (rx_lp_evt), .rx_lp_inv (rx_lp_inv),
        .rx_eop_evt (rx_eop_evt), .rx_eop_inv (rx_eop_inv),
        .auto_pol_dis (auto_pol_dis), .lp_tx (lp_tx), .link_up (link_up),
        .tx_en (tx_en), .rx_en (rx_en), .col_en (col_en),
        .pol_swap (pol_swap), .pol_status (pol_status)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input int got, input int exp);
        n_run = n_run + 1;
        if (got != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic send(input logic eop, input logic inv);
        if (eop) begin rx_eop_evt = 1'b1; rx_eop_inv = inv; end
        else     begin rx_lp_evt  = 1'b1; rx_lp_inv  = inv; end
        tick();
        rx_lp_evt = 1'b0; rx_lp_inv = 1'b0;
        rx_eop_evt = 1'b0; rx_eop_inv = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    initial begin
        int w, p, n;
        @(negedge clk);
        do_reset();

        // R5: state after reset
        check("R5 link_up", link_up, 0);
        check("R5 enables", {tx_en, rx_en, col_en}, 0);
        check("R5 swap/status", {pol_swap, pol_status}, 0);
        check("R5 lp_tx", lp_tx, 0);

        // R1: width and period of generated pulses
        n = 0;
        while (!lp_tx && n < 2 * INTERVAL) begin tick(); n++; end
        w = 0;
        while (lp_tx && w < 4 * PULSE) begin tick(); w++; end
        check("R1 pulse width", w, PULSE);
        p = w;
        while (!lp_tx && p < 2 * INTERVAL) begin tick(); p++; end
        check("R1 pulse period", p, INTERVAL);

        // R2: transmit activity cuts a pulse and restarts the interval
        tx_active = 1'b1;
        tick();
        check("R2 pulse cut", lp_tx, 0);
        w = 0;
        for (int i = 0; i < 8; i++) begin tick(); w += lp_tx; end
        check("R2 quiet during tx", w, 0);
        tx_active = 1'b0;
        n = 0;
        do begin tick(); n++; end while (!lp_tx && n < 2 * INTERVAL);
        check("R2 restart interval", n, INTERVAL);

        // R3: first pulse brings link and enables up
        send(1'b0, 1'b0);
        check("R3 link_up", link_up, 1);
        check("R3 enables", {tx_en, rx_en, col_en}, 3'b111);

        // R4: timeout after exactly LOSS cycles
        repeat (LOSS - 1) tick();
        check("R4 still up", link_up, 1);
        tick();
        check("R4 link lost", link_up, 0);
        check("R4 enables off", {tx_en, rx_en, col_en}, 0);

        // R4: pulse on the expiry edge keeps the link and restarts timer
        send(1'b0, 1'b1);
        repeat (LOSS - 1) tick();
        send(1'b0, 1'b0);
        check("R4 coincident pulse keeps link", link_up, 1);
        repeat (LOSS - 1) tick();
        check("R4 restarted timer up", link_up, 1);
        tick();
        check("R4 restarted timer down", link_up, 0);

        // R6/R8: vector walk of interleaved polarity events
        for (int i = 0; i < NVEC; i++) begin
            send(VEC[i][2], VEC[i][1]);
            check($sformatf("R6/R8 vec %0d swap", i), pol_swap, VEC[i][0]);
            tick();
        end
        check("R6 status", pol_status, 1);
        send(1'b0, 1'b0);
        check("R6 sticky after correct pulse", pol_swap, 1);

        // R9: disable forces swap low at once, clears status next edge
        auto_pol_dis = 1'b1;
        #1;
        check("R9 swap off same cycle", pol_swap, 0);
        tick();
        check("R9 status cleared", pol_status, 0);
        for (int i = 0; i < 3; i++) send(1'b1, 1'b1);
        check("R9 no swap while disabled", {pol_swap, pol_status}, 0);
        auto_pol_dis = 1'b0;
        tick();

        // R7: three inverted packet endings (runs cleared by disable)
        send(1'b1, 1'b1);
        send(1'b1, 1'b1);
        check("R7 after two", pol_swap, 0);
        send(1'b1, 1'b1);
        check("R7 after three", pol_swap, 1);
        check("R7 status", pol_status, 1);

        // R5: reset in mid-run clears everything
        send(1'b0, 1'b0);
        do_reset();
        check("R5 rerun link", link_up, 0);
        check("R5 rerun swap/status", {pol_swap, pol_status}, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

endmodule